// File: doc/BRIEF.md
# System Management Interrupt Entry Controller

This block sits on the request side of a processor bus interface and decides when the core enters system management mode. It watches an active-low interrupt request line on every rising clock. The line is brought into the clock domain through a two-stage synchroniser. The block accepts a request only when the line shows a clean high-to-low transition, with a minimum width on each side. An accepted request waits as pending until the core reports an instruction boundary. At that boundary the block drives an active-low "in SMM" status output and emits a one-clock entry pulse.

Once asserted, the status output stays low until the core executes the resume instruction or the block is reset. A soft reset that arrives while the core is in SMM does not end the mode. The block flags that soft reset as blocked so the surrounding logic can suppress it. Saving processor state, the SMM address space and arbitration against other interrupts are handled elsewhere.

Top module: `smm_entry_ctrl`

## Requirements
- R1: While `rst` is high and on the first edge after it, `smiact_n` is 1, `enter_smm` is 0 and any pending request is discarded. A line that is already low when reset is released is not a request.
- R2: A request is accepted when the synchronised line has been high for at least MIN_HIGH (2) consecutive clocks and then low for at least MIN_LOW (2) consecutive clocks.
- R3: A low period shorter than MIN_LOW, or one that follows a high period shorter than MIN_HIGH, is not accepted and never leads to entry.
- R4: Recognition is edge based. A line that stays low after an accepted request produces no further request until it has returned high for MIN_HIGH clocks.
- R5: An accepted request stays pending for any number of clocks without an instruction boundary. `smiact_n` falls on the rising edge where `instr_boundary` is sampled high with a request pending.
- R6: `enter_smm` is high for exactly one clock, in the same cycle in which `smiact_n` first reads low.
- R7: `smiact_n` stays low until `rsm_exec` is sampled high or reset. It reads 1 after the edge that samples `rsm_exec`.
- R8: A request that completes while `smiact_n` is low is discarded. It does not cause a new entry after the resume.
- R9: `sreset` never changes `smiact_n`. `sreset_blocked` is 1 exactly in cycles where `sreset` is high and `smiact_n` is low.
- R10: With `instr_boundary` held high, `smiact_n` reads low after the 5th rising edge (SYNC_STAGES + MIN_LOW + 1), counting the first edge that samples `smi_n` low as edge 1.
- R11: `rsm_exec` outside SMM has no effect. In particular, it does not cancel a pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| smi_n | input | 1 | Asynchronous active-low management interrupt request |
| instr_boundary | input | 1 | High in a cycle that ends an instruction |
| rsm_exec | input | 1 | High when the resume instruction executes |
| sreset | input | 1 | Soft reset request from the system |
| smiact_n | output | 1 | Active-low "in management mode" status, always driven |
| enter_smm | output | 1 | One-clock pulse on mode entry |
| sreset_blocked | output | 1 | Soft reset arrived while in management mode |

## Verification
The bound checker watches the mode output on every cycle. It checks that each fall of `smiact_n` coincides with a single-cycle entry pulse and follows a sampled instruction boundary. It checks that the mode holds until a resume is sampled, that a soft reset never disturbs it, and that the blocked flag tracks soft reset inside the mode. The width qualification and the dropping of requests cannot be seen from any single cycle, so only the bench scenarios show them. These cover the sweep of high and low widths, the level-held line, the request made during SMM, and the reset that cancels a pending request.

// File: rtl/smm_entry_pkg.sv
package smm_entry_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_PEND   = 2'd1,
        MODE_ACTIVE = 2'd2
    } smm_mode_e;

    // Width of a counter that must hold values 0..max_val
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/smm_line_sync.sv
module smm_line_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/smm_edge_qual.sv
module smm_edge_qual
    import smm_entry_pkg::*;
#(
    parameter int MIN_HIGH = 2,
    parameter int MIN_LOW  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_n,
    output logic req_fire
);
    localparam int HW = cnt_width(MIN_HIGH);
    localparam int LW = cnt_width(MIN_LOW);
    localparam logic [HW-1:0] H_MAX  = HW'(MIN_HIGH);
    localparam logic [HW-1:0] H_LAST = HW'(MIN_HIGH - 1);
    localparam logic [LW-1:0] L_MAX  = LW'(MIN_LOW);
    localparam logic [LW-1:0] L_LAST = LW'(MIN_LOW - 1);

    logic [HW-1:0] high_run;
    logic [LW-1:0] low_run;
    logic          armed;

    // Fires on the MIN_LOW-th low sample of a run that follows a long enough high run
    assign req_fire = !line_n && armed && (low_run == L_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            high_run <= '0;
            low_run  <= '0;
            armed    <= 1'b0;
        end else begin
            if (line_n) begin
                low_run  <= '0;
                high_run <= (high_run == H_MAX) ? H_MAX : high_run + 1'b1;
                armed    <= (high_run >= H_LAST);
            end else begin
                high_run <= '0;
                low_run  <= (low_run == L_MAX) ? L_MAX : low_run + 1'b1;
                if (req_fire) armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/smm_mode_ctrl.sv
module smm_mode_ctrl
    import smm_entry_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_fire,
    input  logic instr_boundary,
    input  logic rsm_exec,
    input  logic sreset,
    output logic in_smm,
    output logic enter_pulse,
    output logic sreset_blk
);
    smm_mode_e mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= MODE_IDLE;
            enter_pulse <= 1'b0;
        end else begin
            enter_pulse <= 1'b0;
            unique case (mode)
                MODE_IDLE:   if (req_fire) mode <= MODE_PEND;
                MODE_PEND:   if (instr_boundary) begin
                                 mode        <= MODE_ACTIVE;
                                 enter_pulse <= 1'b1;
                             end
                MODE_ACTIVE: if (rsm_exec) mode <= MODE_IDLE;
                default:     mode <= MODE_IDLE;
            endcase
        end
    end

    assign in_smm     = (mode == MODE_ACTIVE);
    assign sreset_blk = sreset && in_smm;
endmodule

// File: rtl/smm_entry_ctrl.sv
module smm_entry_ctrl
    import smm_entry_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HIGH    = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic smi_n,
    input  logic instr_boundary,
    input  logic rsm_exec,
    input  logic sreset,
    output logic smiact_n,
    output logic enter_smm,
    output logic sreset_blocked
);
    logic line_s;
    logic fire;
    logic in_smm;

    // Reset value low: a line held low across reset shows no falling edge
    smm_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (smi_n),
        .q_sync  (line_s)
    );

    smm_edge_qual #(.MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .line_n   (line_s),
        .req_fire (fire)
    );

    smm_mode_ctrl u_mode (
        .clk            (clk),
        .rst            (rst),
        .req_fire       (fire),
        .instr_boundary (instr_boundary),
        .rsm_exec       (rsm_exec),
        .sreset         (sreset),
        .in_smm         (in_smm),
        .enter_pulse    (enter_smm),
        .sreset_blk     (sreset_blocked)
    );

    assign smiact_n = !in_smm;
endmodule

// File: rtl/smm_entry_ctrl_chk.sv
module smm_entry_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic instr_boundary,
    input logic rsm_exec,
    input logic sreset,
    input logic smiact_n,
    input logic enter_smm,
    input logic sreset_blocked
);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (smiact_n && !enter_smm));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        enter_smm |=> !enter_smm);

    a_r6_pulse_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(smiact_n) |-> enter_smm);

    a_r6_fall_on_pulse: assert property (@(posedge clk) disable iff (rst)
        enter_smm |-> (!smiact_n && $past(smiact_n)));

    a_r5_entry_at_boundary: assert property (@(posedge clk) disable iff (rst)
        $fell(smiact_n) |-> $past(instr_boundary));

    a_r7_hold_until_resume: assert property (@(posedge clk) disable iff (rst)
        (!smiact_n && !rsm_exec) |=> !smiact_n);

    a_r7_exit_on_resume: assert property (@(posedge clk) disable iff (rst)
        (!smiact_n && rsm_exec) |=> smiact_n);

    a_r9_flag_only_in_smm: assert property (@(posedge clk) disable iff (rst)
        sreset_blocked |-> (sreset && !smiact_n));

    a_r9_flag_when_blocked: assert property (@(posedge clk) disable iff (rst)
        (sreset && !smiact_n) |-> sreset_blocked);
endmodule

bind smm_entry_ctrl smm_entry_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .instr_boundary (instr_boundary),
    .rsm_exec       (rsm_exec),
    .sreset         (sreset),
    .smiact_n       (smiact_n),
    .enter_smm      (enter_smm),
    .sreset_blocked (sreset_blocked)
);

// File: tb/smm_entry_ctrl_bench.sv
`timescale 1ns/1ps
module smm_entry_ctrl_bench;
    localparam int SYNC_STAGES = 2;
    localparam int MIN_HIGH    = 2;
    localparam int MIN_LOW     = 2;
    localparam int LATENCY     = SYNC_STAGES + MIN_LOW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smi_n = 1'b0;
    logic instr_boundary = 1'b0;
    logic rsm_exec = 1'b0;
    logic sreset = 1'b0;
    logic smiact_n, enter_smm, sreset_blocked;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    smm_entry_ctrl #(.SYNC_STAGES(SYNC_STAGES), .MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW))
    u_smm_entry_ctrl (
        .clk(clk), .rst(rst), .smi_n(smi_n), .instr_boundary(instr_boundary),
        .rsm_exec(rsm_exec), .sreset(sreset), .smiact_n(smiact_n),
        .enter_smm(enter_smm), .sreset_blocked(sreset_blocked)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smi_n = 1'b0; instr_boundary = 1'b0; rsm_exec = 1'b0; sreset = 1'b0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(6);
    endtask

    task automatic give_req(input int hi, input int lo);
        smi_n = 1'b1; wait_cyc(hi);
        smi_n = 1'b0; wait_cyc(lo);
        smi_n = 1'b1; wait_cyc(8);
    endtask

    // Pulse the boundary for one clock and check whether entry happened
    task automatic boundary_expect(input string req, input bit entry);
        instr_boundary = 1'b1;
        @(negedge clk);
        instr_boundary = 1'b0;
        check({req, " smiact_n after boundary"}, smiact_n, entry ? 0 : 1);
        check({req, " enter_smm after boundary"}, enter_smm, entry ? 1 : 0);
        @(negedge clk);
        check({req, " enter_smm next cycle"}, enter_smm, 0);
    endtask

    task automatic resume();
        rsm_exec = 1'b1;
        @(negedge clk);
        rsm_exec = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        wait_cyc(2);
        check("R1 smiact_n in reset", smiact_n, 1);
        check("R1 enter_smm in reset", enter_smm, 0);
        check("R1 sreset_blocked in reset", sreset_blocked, 0);
        rst = 1'b0;
        wait_cyc(8);
        // R1: line low across reset release is not a request
        boundary_expect("R1 low line at release", 1'b0);

        // R2/R3: sweep high and low widths
        for (int hi = 1; hi <= 4; hi++) begin
            for (int lo = 1; lo <= 4; lo++) begin
                do_reset();
                give_req(hi, lo);
                boundary_expect((hi >= MIN_HIGH && lo >= MIN_LOW) ? "R2 width sweep" : "R3 width sweep",
                                (hi >= MIN_HIGH && lo >= MIN_LOW));
            end
        end

        // R5: pending survives a long wait without boundary
        do_reset();
        give_req(3, 3);
        wait_cyc(40);
        check("R5 no entry without boundary", smiact_n, 1);
        boundary_expect("R5 late boundary", 1'b1);
        // R7: stays in mode until resume
        wait_cyc(20);
        check("R7 held in mode", smiact_n, 0);
        resume();
        check("R7 exit after resume", smiact_n, 1);

        // R10: latency with boundary held high
        do_reset();
        smi_n = 1'b1; wait_cyc(4);
        instr_boundary = 1'b1;
        smi_n = 1'b0;
        for (int e = 1; e <= LATENCY; e++) begin
            @(posedge clk); #1;
            check($sformatf("R10 smiact_n after edge %0d", e), smiact_n, (e < LATENCY) ? 1 : 0);
        end
        instr_boundary = 1'b0;
        smi_n = 1'b1;
        wait_cyc(2);

        // R4: line kept low after an accepted request gives no second request
        do_reset();
        smi_n = 1'b1; wait_cyc(3);
        smi_n = 1'b0; wait_cyc(6);
        boundary_expect("R4 first entry", 1'b1);
        resume();
        wait_cyc(10);
        boundary_expect("R4 held low line", 1'b0);

        // R8: request completed inside the mode is dropped
        do_reset();
        give_req(2, 2);
        boundary_expect("R8 entry", 1'b1);
        give_req(3, 3);
        check("R8 still in mode", smiact_n, 0);
        resume();
        check("R8 resumed", smiact_n, 1);
        boundary_expect("R8 dropped request", 1'b0);

        // R9: soft reset inside and outside the mode
        do_reset();
        sreset = 1'b1; #1;
        check("R9 blocked flag outside mode", sreset_blocked, 0);
        @(negedge clk);
        sreset = 1'b0;
        check("R9 smiact_n after soft reset outside", smiact_n, 1);
        give_req(2, 2);
        boundary_expect("R9 entry", 1'b1);
        sreset = 1'b1; #1;
        check("R9 blocked flag in mode", sreset_blocked, 1);
        wait_cyc(3);
        sreset = 1'b0;
        check("R9 mode kept after soft reset", smiact_n, 0);
        #1;
        check("R9 flag clears", sreset_blocked, 0);
        resume();

        // R11: resume outside the mode leaves a pending request intact
        do_reset();
        give_req(2, 3);
        resume();
        check("R11 resume while pending", smiact_n, 1);
        boundary_expect("R11 pending survives resume", 1'b1);

        // R1: reset clears a pending request and exits the mode
        do_reset();
        give_req(2, 2);
        do_reset();
        boundary_expect("R1 pending cleared by reset", 1'b0);
        give_req(2, 2);
        boundary_expect("R1 entry before reset", 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset exits mode", smiact_n, 1);
        rst = 1'b0;
        wait_cyc(2);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule